// File: doc/BRIEF.md
# Keyed Write-Lock Guard

This block stands between a register bus and a bank of configuration registers and decides, for each write strobe, whether the addressed register may take the data. Most of the bank is key-protected. Software first writes two fixed values in a row to a dedicated key register. That opens the bank for exactly one write. The next write to any protected register, or to the key register itself, closes the bank again.

On top of the key there is a sticky hard-lock bit. It lives in one of the protected registers. Once a permitted write sets it, a chosen subset of registers refuses every further write, whatever the key state. Only reset clears it. A refused write is dropped: no permit bit goes high, and a one-cycle error pulse follows. The block owns only the key state and the hard-lock bit. The contents of the guarded registers live elsewhere and use the permit vector as their write enable.

Top module: `wlk_guard`

## Requirements
- R1: After reset, key_state reads 0 (closed), hard_locked is 0, wr_err is 0, and wr_permit is all zeros.
- R2: A key write (address 3) whose low 8 data bits equal 0xA5 while key_state is 0 makes key_state read 1 (armed) from the next cycle. Data bits above bit 7 are ignored.
- R3: A key write with low byte 0xF1 while key_state is 1 makes key_state read 2 (open) from the next cycle.
- R4: A key write whose low byte is not the value expected next (0xA5 when closed, 0xF1 when armed) makes key_state read 0 from the next cycle.
- R5: Any key write while key_state is 2 makes key_state read 0 from the next cycle, whatever the data.
- R6: A write to a key-protected register (addresses 0, 1, 2 and 4 to 11 by default) while key_state is not 2 raises no wr_permit bit, and wr_err is 1 in the next cycle only.
- R7: While key_state is 2, a write to a key-protected register that the hard lock does not block raises wr_permit bit [address] in the same cycle. The write returns key_state to 0 from the next cycle, so a second such write is refused.
- R8: A write to a register that is neither key-protected nor hard-locked (addresses 12 to 15 by default) always raises wr_permit bit [address] in the same cycle and leaves key_state unchanged.
- R9: A permitted write to the lock register (address 1) with data bit 31 at 1 makes hard_locked read 1 from the next cycle. A permitted write with bit 31 at 0 leaves it at 0.
- R10: While hard_locked is 1, writes to hard-locked registers (addresses 1, 2 and 4 to 7 by default) are refused with a wr_err pulse the next cycle, even when key_state is 2. Such a write still returns key_state to 0. Key-protected registers outside that subset stay writable through the key.
- R11: hard_locked stays 1 until reset, whatever is written to the lock register.
- R12: A key write never raises a wr_permit bit and never causes a wr_err pulse.
- R13: With wr_en low, wr_permit is all zeros, wr_err is 0 in the next cycle, and key_state and hard_locked do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe of the register bus |
| wr_addr | input | AW | Register index of the write |
| wr_data | input | DW | Write data |
| wr_permit | output | 2**AW | One-hot write enable for the addressed register, same cycle as the strobe |
| wr_err | output | 1 | One-cycle pulse, one cycle after a refused write |
| key_state | output | 2 | Key status: 0 closed, 1 armed, 2 open |
| hard_locked | output | 1 | Sticky hard-lock bit |

## Verification
The hardest case to reach is a write that is key-permitted but refused by the hard lock. It needs the full two-value key sequence, then a permitted write that sets the lock bit, then a second unlock, and then a write to a hard-locked register while the bank is open. It must show both the refusal and the relock. The directed part of the stimulus walks through that sequence. It also checks that a key-protected register outside the hard subset still opens, and that only reset clears the lock. A long biased random phase follows, with most key writes carrying one of the two valid values. That keeps the armed and open states frequent. A behavioural model compares every output on every clock.

// File: rtl/wlk_pkg.sv
package wlk_pkg;
   typedef enum logic [1:0] {
      KS_CLOSED = 2'd0,
      KS_ARMED  = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;
endpackage

// File: rtl/wlk_key_fsm.sv
module wlk_key_fsm
   import wlk_pkg::*;
#(
   parameter int          KEY_W      = 8,
   parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hA5,
   parameter logic [KEY_W-1:0] KEY_SECOND = 8'hF1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic             prot_wr,
   input  logic [KEY_W-1:0] key_val,
   output key_state_e       state
);
   key_state_e state_nx;

   always_comb begin
      state_nx = state;
      if (key_wr) begin
         unique case (state)
            KS_CLOSED: state_nx = (key_val == KEY_FIRST)  ? KS_ARMED : KS_CLOSED;
            KS_ARMED:  state_nx = (key_val == KEY_SECOND) ? KS_OPEN  : KS_CLOSED;
            default:   state_nx = KS_CLOSED;
         endcase
      end else if (prot_wr && state == KS_OPEN) begin
         state_nx = KS_CLOSED;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= KS_CLOSED;
      else        state <= state_nx;
   end
endmodule

// File: rtl/wlk_sticky_lock.sv
module wlk_sticky_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   output logic locked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       locked <= 1'b0;
      else if (set_req) locked <= 1'b1;
   end
endmodule

// File: rtl/wlk_gate.sv
module wlk_gate #(
   parameter int AW       = 4,
   parameter int KEY_ADDR = 3,
   parameter logic [(1<<AW)-1:0] PROT_MASK = 16'h0FF7,
   parameter logic [(1<<AW)-1:0] HARD_MASK = 16'h00F6,
   localparam int NREG = 1 << AW
) (
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic            is_open,
   input  logic            hard_on,
   output logic            key_wr,
   output logic            prot_wr,
   output logic            blocked,
   output logic            accept,
   output logic [NREG-1:0] permit
);
   logic prot_hit, hard_hit;

   assign key_wr   = wr_en && (wr_addr == AW'(KEY_ADDR));
   assign prot_hit = wr_en && PROT_MASK[wr_addr];
   assign hard_hit = wr_en && HARD_MASK[wr_addr];
   assign prot_wr  = prot_hit;
   assign blocked  = (prot_hit && !is_open) || (hard_hit && hard_on);
   assign accept   = wr_en && !key_wr && !blocked;

   for (genvar i = 0; i < NREG; i++) begin : g_permit
      assign permit[i] = accept && (wr_addr == AW'(i));
   end
endmodule

// File: rtl/wlk_guard.sv
module wlk_guard
   import wlk_pkg::*;
#(
   parameter int AW        = 4,
   parameter int DW        = 32,
   parameter int KEY_W     = 8,
   parameter int KEY_ADDR  = 3,
   parameter int LOCK_ADDR = 1,
   parameter int LOCK_BIT  = 31,
   parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hA5,
   parameter logic [KEY_W-1:0] KEY_SECOND = 8'hF1,
   parameter logic [(1<<AW)-1:0] PROT_MASK = 16'h0FF7,
   parameter logic [(1<<AW)-1:0] HARD_MASK = 16'h00F6,
   localparam int NREG = 1 << AW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   output logic [NREG-1:0] wr_permit,
   output logic            wr_err,
   output logic [1:0]      key_state,
   output logic            hard_locked
);
   if (KEY_W > DW)                  begin : g_bad_keyw  $error("KEY_W exceeds DW");            end
   if (LOCK_BIT >= DW)              begin : g_bad_lbit  $error("LOCK_BIT outside data");       end
   if (KEY_ADDR >= NREG)            begin : g_bad_kadr  $error("KEY_ADDR outside bank");       end
   if (LOCK_ADDR >= NREG)           begin : g_bad_ladr  $error("LOCK_ADDR outside bank");      end
   if (PROT_MASK[KEY_ADDR])         begin : g_bad_kprot $error("key register in PROT_MASK");   end
   if (HARD_MASK[KEY_ADDR])         begin : g_bad_khard $error("key register in HARD_MASK");   end
   if (!HARD_MASK[LOCK_ADDR])       begin : g_bad_lhard $error("lock register not in HARD_MASK"); end
   if (KEY_FIRST == KEY_SECOND)     begin : g_bad_keys  $error("key values must differ");      end

   key_state_e st;
   logic       key_wr, prot_wr, blocked, accept, lock_set;
   logic       unused_data;

   assign unused_data = ^wr_data;

   wlk_gate #(
      .AW(AW), .KEY_ADDR(KEY_ADDR), .PROT_MASK(PROT_MASK), .HARD_MASK(HARD_MASK)
   ) gate_i (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .is_open (st == KS_OPEN),
      .hard_on (hard_locked),
      .key_wr  (key_wr),
      .prot_wr (prot_wr),
      .blocked (blocked),
      .accept  (accept),
      .permit  (wr_permit)
   );

   wlk_key_fsm #(
      .KEY_W(KEY_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
   ) fsm_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .key_wr  (key_wr),
      .prot_wr (prot_wr),
      .key_val (wr_data[KEY_W-1:0]),
      .state   (st)
   );

   assign lock_set = accept && (wr_addr == AW'(LOCK_ADDR)) && wr_data[LOCK_BIT];

   wlk_sticky_lock lock_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (lock_set),
      .locked  (hard_locked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_err <= 1'b0;
      else        wr_err <= blocked;
   end

   assign key_state = st;
endmodule

// File: rtl/wlk_guard_chk.sv
module wlk_guard_chk #(
   parameter int AW        = 4,
   parameter int DW        = 32,
   parameter int KEY_W     = 8,
   parameter int KEY_ADDR  = 3,
   parameter logic [KEY_W-1:0] KEY_SECOND = 8'hF1,
   parameter logic [(1<<AW)-1:0] PROT_MASK = 16'h0FF7,
   parameter logic [(1<<AW)-1:0] HARD_MASK = 16'h00F6,
   localparam int NREG = 1 << AW
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [AW-1:0]   wr_addr,
   input logic [DW-1:0]   wr_data,
   input logic [NREG-1:0] wr_permit,
   input logic            wr_err,
   input logic [1:0]      key_state,
   input logic            hard_locked
);
   logic key_hit;
   assign key_hit = wr_en && (wr_addr == AW'(KEY_ADDR));

   p_permit_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_permit));

   p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (wr_permit == '0));

   p_idle_no_err_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !wr_err);

   p_closed_refuses_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && PROT_MASK[wr_addr] && key_state != 2'd2) |-> (wr_permit == '0));

   p_closed_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && PROT_MASK[wr_addr] && key_state != 2'd2) |=> wr_err);

   p_relock_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (key_hit && key_state == 2'd2) |=> (key_state == 2'd0));

   p_relock_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && PROT_MASK[wr_addr] && key_state == 2'd2) |=> (key_state == 2'd0));

   p_second_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (key_hit && key_state == 2'd1 && wr_data[KEY_W-1:0] == KEY_SECOND) |=> (key_state == 2'd2));

   p_key_no_permit_r12: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit |-> (wr_permit == '0));

   p_key_no_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit |=> !wr_err);

   p_hard_refuses_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && HARD_MASK[wr_addr] && hard_locked) |-> (wr_permit == '0));

   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hard_locked |=> hard_locked);

   p_free_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !PROT_MASK[wr_addr] && !HARD_MASK[wr_addr] && !key_hit) |-> wr_permit[wr_addr]);

   p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      key_state != 2'd3);
endmodule

bind wlk_guard wlk_guard_chk #(
   .AW(AW), .DW(DW), .KEY_W(KEY_W), .KEY_ADDR(KEY_ADDR), .KEY_SECOND(KEY_SECOND),
   .PROT_MASK(PROT_MASK), .HARD_MASK(HARD_MASK)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .wr_permit(wr_permit), .wr_err(wr_err), .key_state(key_state), .hard_locked(hard_locked)
);

// File: tb/wlk_guard_tb.sv
module wlk_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [15:0] wr_permit;
   logic        wr_err;
   logic [1:0]  key_state;
   logic        hard_locked;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   int m_state = 0;
   bit m_hard  = 1'b0;
   bit m_err   = 1'b0;

   always #4 clk = ~clk;

   wlk_guard dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_permit(wr_permit), .wr_err(wr_err), .key_state(key_state), .hard_locked(hard_locked)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: run did not finish, act=%0d cycles exp<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   function automatic bit is_prot(int a);
      return (a == 0 || a == 1 || a == 2 || (a >= 4 && a <= 11));
   endfunction

   function automatic bit is_hard(int a);
      return (a == 1 || a == 2 || (a >= 4 && a <= 7));
   endfunction

   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      m_state = 0; m_hard = 1'b0; m_err = 1'b0;
      @(negedge clk);
      #1;
      chk(key_state == 2'd0, "R1", "key_state in reset", key_state, 0);
      chk(hard_locked == 1'b0, "R11", "hard_locked cleared by reset", hard_locked, 0);
      chk(wr_err == 1'b0, "R1", "wr_err in reset", wr_err, 0);
      chk(wr_permit == '0, "R1", "wr_permit in reset", wr_permit, 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one bus cycle: drive, compare every output against the model, advance the model
   task automatic cyc_op(bit en, int a, logic [31:0] d, string tag);
      bit          kw, pw, hw, blk;
      logic [15:0] ep;
      int          ns;
      @(negedge clk);
      wr_en = en; wr_addr = 4'(a); wr_data = d;
      #1;
      kw  = en && (a == 3);
      pw  = en && is_prot(a);
      hw  = en && is_hard(a);
      blk = (pw && m_state != 2) || (hw && m_hard);
      ep  = (en && !kw && !blk) ? (16'd1 << a) : 16'd0;
      chk(wr_permit == ep, tag, "wr_permit", wr_permit, ep);
      chk(key_state == 2'(m_state), tag, "key_state", key_state, m_state);
      chk(hard_locked == m_hard, tag, "hard_locked", hard_locked, m_hard);
      chk(wr_err == m_err, tag, "wr_err", wr_err, m_err);
      ns = m_state;
      if (kw) begin
         if (m_state == 0)      ns = (d[7:0] == 8'hA5) ? 1 : 0;
         else if (m_state == 1) ns = (d[7:0] == 8'hF1) ? 2 : 0;
         else                   ns = 0;
      end else if (pw && m_state == 2) begin
         ns = 0;
      end
      if (ep != 0 && a == 1 && d[31]) m_hard = 1'b1;
      m_state = ns;
      m_err   = blk;
   endtask

   task automatic unlock(string tag);
      cyc_op(1'b1, 3, 32'h0000_00A5, tag);
      cyc_op(1'b1, 3, 32'h0000_00F1, tag);
   endtask

   initial begin
      do_reset();
      cyc_op(1'b0, 5, 32'h1234, "R13");
      cyc_op(1'b0, 3, 32'hA5, "R13");
      cyc_op(1'b1, 5, 32'h1, "R6");
      cyc_op(1'b1, 0, 32'h2, "R6");
      cyc_op(1'b0, 0, 32'h0, "R6");
      cyc_op(1'b1, 3, 32'hFFFF_FFA5, "R2");
      cyc_op(1'b1, 12, 32'h7, "R8");
      cyc_op(1'b1, 15, 32'h7, "R8");
      cyc_op(1'b1, 3, 32'h0000_00F1, "R3");
      cyc_op(1'b1, 9, 32'h55, "R7");
      cyc_op(1'b1, 9, 32'h56, "R7");
      cyc_op(1'b0, 0, 32'h0, "R7");
      cyc_op(1'b1, 3, 32'h11, "R4");
      cyc_op(1'b1, 3, 32'hA5, "R4");
      cyc_op(1'b1, 3, 32'h00, "R4");
      cyc_op(1'b1, 3, 32'hA5, "R4");
      cyc_op(1'b1, 3, 32'hA5, "R4");
      cyc_op(1'b1, 3, 32'hF1, "R4");
      unlock("R5");
      cyc_op(1'b1, 3, 32'hA5, "R5");
      cyc_op(1'b1, 3, 32'h00, "R12");
      unlock("R9");
      cyc_op(1'b1, 1, 32'h7FFF_FFFF, "R9");
      cyc_op(1'b0, 0, 32'h0, "R9");
      unlock("R9");
      cyc_op(1'b1, 1, 32'h8000_0000, "R9");
      cyc_op(1'b0, 0, 32'h0, "R9");
      unlock("R10");
      cyc_op(1'b1, 5, 32'h9, "R10");
      cyc_op(1'b1, 5, 32'h9, "R10");
      unlock("R10");
      cyc_op(1'b1, 10, 32'h9, "R10");
      cyc_op(1'b1, 14, 32'h9, "R8");
      unlock("R11");
      cyc_op(1'b1, 1, 32'h0, "R11");
      cyc_op(1'b0, 0, 32'h0, "R11");
      do_reset();
      cyc_op(1'b0, 0, 32'h0, "R11");
      for (int i = 0; i < 4000; i++) begin
         int          a;
         logic [31:0] d;
         int          pick;
         pick = int'($urandom_range(0, 9));
         a    = (pick < 4) ? 3 : int'($urandom_range(0, 15));
         d    = $urandom();
         if (a == 3 && pick < 3) d[7:0] = (pick == 0) ? 8'hA5 : 8'hF1;
         cyc_op($urandom_range(0, 5) != 0, a, d, "R7");
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule